// File: doc/BRIEF.md
# Software-Managed Incoherent Data Cache

This block is a small per-core data cache with no coherence hardware at all. The core reaches it only through dedicated cached load and store operations; every other access goes around it. When a cached access misses, the hardware fetches the whole line from the backing store the address maps to. When a modified line is displaced, the hardware writes it back first. Keeping copies in different cores consistent is left entirely to software.

Software does that through three maintenance operations. Prefetch pulls a line in without returning anything to the core. Invalidate drops a line and throws away any modified data, with no write to the backing store. Refresh re-reads a resident line from the backing store, replacing whatever is held locally.

The organisation is direct-mapped with one outstanding miss. The core side is a valid/ready request channel with a one-cycle response strobe. The memory side moves whole lines: a request channel with a write flag, and a read-data strobe.

Top module: `swmc_cache`

## Requirements
- R1: A load that hits returns the addressed word with `core_rsp_valid` in the cycle after acceptance, and issues no memory request.
- R2: The core address is a word address. Bits [1:0] select the word in the line, bits [4:2] select the line, and the remaining bits form the tag. A load or store that misses on an invalid or clean line issues one read of line address `core_req_addr >> 2`. `core_req_ready` stays low from acceptance until the response cycle. Word k of a line occupies bits [32k+31:32k].
- R3: A store writes its word into the line and marks the line modified. A store that misses first fills the line and then merges the word. Later loads return the stored word.
- R4: Before the fill read, a miss that displaces a modified line writes the whole old line to that line's own line address.
- R5: A prefetch that misses fills the line exactly as a load miss would, and a later load to it hits. A prefetch that hits completes in the next cycle with no memory traffic.
- R6: An invalidate on a resident line removes it and discards modified data without any memory write. A later load to that line refetches the backing-store contents.
- R7: A refresh on a resident line issues exactly one line read and no write, even when the line is modified. It replaces the local data and clears the modified mark, so a later displacement writes nothing back.
- R8: Invalidate and refresh on a non-resident line complete in the cycle after acceptance with no memory traffic.
- R9: Reset leaves every line invalid, `core_req_ready` high, and both `core_rsp_valid` and `mem_req_valid` low.
- R10: Once `mem_req_valid` is raised, the request keeps its valid, write flag, address and data unchanged until `mem_req_ready` accepts it.
- R11: Operation codes are load=0, store=1, prefetch=2, invalidate=3, refresh=4. Codes 5 to 7 complete in the next cycle and change neither the cache nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Cache can accept a request |
| core_req_op | input | 3 | Operation code |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | DATA_W | Store data |
| core_rsp_valid | output | 1 | One-cycle completion strobe |
| core_rsp_rdata | output | DATA_W | Load result |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | ADDR_W-2 | Line address |
| mem_req_wdata | output | WORDS*DATA_W | Writeback line |
| mem_rsp_valid | input | 1 | Read line returned |
| mem_rsp_rdata | input | WORDS*DATA_W | Returned line |

## Verification
Hits, unknown codes and all maintenance operations on non-resident lines must raise the response exactly one cycle after the accepting edge. Misses raise the memory read the cycle after acceptance, or the cycle after the writeback is taken, and respond one cycle after the fill beat. The bench drives and samples on the falling edge. It counts falling edges from acceptance to the strobe and requires a count of exactly one whenever no memory read was expected. A monitor counts line reads and writes per operation, so every expected fill and writeback, and every forbidden one, is checked against the table.

// File: rtl/swmc_pkg.sv
package swmc_pkg;
   localparam logic [2:0] OP_LOAD     = 3'd0;
   localparam logic [2:0] OP_STORE    = 3'd1;
   localparam logic [2:0] OP_PREFETCH = 3'd2;
   localparam logic [2:0] OP_INVAL    = 3'd3;
   localparam logic [2:0] OP_REFRESH  = 3'd4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_RD   = 2'd2,
      ST_WAIT = 2'd3
   } swmc_state_e;
endpackage

// File: rtl/swmc_tag_store.sv
module swmc_tag_store #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3,
   parameter int TAG_W     = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             wr_en,
   input  logic             wr_valid,
   input  logic             wr_dirty,
   input  logic [TAG_W-1:0] wr_tag,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag
);
   logic             valid_a [NUM_LINES];
   logic             dirty_a [NUM_LINES];
   logic [TAG_W-1:0] tag_a   [NUM_LINES];

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic             valid_q;
      logic             dirty_q;
      logic [TAG_W-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
            tag_q   <= '0;
         end else if (wr_en && idx == IDX_W'(l)) begin
            valid_q <= wr_valid;
            dirty_q <= wr_dirty;
            tag_q   <= wr_tag;
         end
      end
      assign valid_a[l] = valid_q;
      assign dirty_a[l] = dirty_q;
      assign tag_a[l]   = tag_q;
   end

   assign rd_valid = valid_a[idx];
   assign rd_dirty = dirty_a[idx];
   assign rd_tag   = tag_a[idx];
endmodule

// File: rtl/swmc_data_store.sv
module swmc_data_store #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3,
   parameter int WORDS     = 4,
   parameter int OFF_W     = 2,
   parameter int DATA_W    = 32,
   localparam int LINE_W   = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              line_we,
   input  logic [LINE_W-1:0] line_wdata,
   input  logic              word_we,
   input  logic [OFF_W-1:0]  word_off,
   input  logic [DATA_W-1:0] word_wdata,
   output logic [LINE_W-1:0] line_rdata
);
   logic [LINE_W-1:0] line_a [NUM_LINES];

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [LINE_W-1:0] line_q;
      always_ff @(posedge clk) begin
         if (line_we && idx == IDX_W'(l)) begin
            line_q <= line_wdata;
         end else if (word_we && idx == IDX_W'(l)) begin
            for (int w = 0; w < WORDS; w++) begin
               if (OFF_W'(w) == word_off) line_q[w*DATA_W +: DATA_W] <= word_wdata;
            end
         end
      end
      assign line_a[l] = line_q;
   end

   assign line_rdata = line_a[idx];
endmodule

// File: rtl/swmc_ctrl.sv
module swmc_ctrl
   import swmc_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int WORDS   = 4,
   parameter int IDX_W   = 3,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LA_W   = ADDR_W - OFF_W,
   localparam int TAG_W  = LA_W - IDX_W,
   localparam int LINE_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req_valid,
   output logic              core_req_ready,
   input  logic [2:0]        core_req_op,
   input  logic [ADDR_W-1:0] core_req_addr,
   input  logic [DATA_W-1:0] core_req_wdata,
   output logic              core_rsp_valid,
   output logic [DATA_W-1:0] core_rsp_rdata,
   output logic [IDX_W-1:0]  lk_idx,
   input  logic              lk_valid,
   input  logic              lk_dirty,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [LINE_W-1:0] line_rdata,
   output logic              tag_we,
   output logic              tag_wvalid,
   output logic              tag_wdirty,
   output logic [TAG_W-1:0]  tag_wtag,
   output logic              line_we,
   output logic [LINE_W-1:0] line_wdata,
   output logic              word_we,
   output logic [OFF_W-1:0]  word_off,
   output logic [DATA_W-1:0] word_wdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [LA_W-1:0]   mem_req_addr,
   output logic [LINE_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [LINE_W-1:0] mem_rsp_rdata
);
   swmc_state_e       state_q, state_d;
   logic [2:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rsp_q, rsp_d;
   logic [DATA_W-1:0] rdata_q, rdata_d;

   logic [ADDR_W-1:0] cur_addr;
   logic [2:0]        cur_op;
   logic [DATA_W-1:0] cur_wdata;
   logic [OFF_W-1:0]  cur_off;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   logic              hit;
   logic              accept;
   logic [DATA_W-1:0] hit_word;
   logic [DATA_W-1:0] fill_word;
   logic [LINE_W-1:0] fill_line;

   assign core_req_ready = (state_q == ST_IDLE);
   assign accept         = core_req_valid && core_req_ready;
   assign core_rsp_valid = rsp_q;
   assign core_rsp_rdata = rdata_q;

   always_comb begin
      cur_addr  = (state_q == ST_IDLE) ? core_req_addr  : addr_q;
      cur_op    = (state_q == ST_IDLE) ? core_req_op    : op_q;
      cur_wdata = (state_q == ST_IDLE) ? core_req_wdata : wdata_q;
      cur_off   = cur_addr[OFF_W-1:0];
      cur_idx   = cur_addr[OFF_W +: IDX_W];
      cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
      hit       = lk_valid && (lk_tag == cur_tag);
      hit_word  = '0;
      fill_word = '0;
      fill_line = mem_rsp_rdata;
      for (int w = 0; w < WORDS; w++) begin
         if (OFF_W'(w) == cur_off) begin
            hit_word  = line_rdata[w*DATA_W +: DATA_W];
            fill_word = mem_rsp_rdata[w*DATA_W +: DATA_W];
            if (cur_op == OP_STORE) fill_line[w*DATA_W +: DATA_W] = cur_wdata;
         end
      end
   end

   always_comb begin
      state_d       = state_q;
      rsp_d         = 1'b0;
      rdata_d       = rdata_q;
      lk_idx        = cur_idx;
      tag_we        = 1'b0;
      tag_wvalid    = 1'b0;
      tag_wdirty    = 1'b0;
      tag_wtag      = cur_tag;
      line_we       = 1'b0;
      line_wdata    = fill_line;
      word_we       = 1'b0;
      word_off      = cur_off;
      word_wdata    = cur_wdata;
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = {cur_tag, cur_idx};
      mem_req_wdata = line_rdata;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               case (cur_op)
                  OP_LOAD, OP_STORE, OP_PREFETCH: begin
                     if (hit) begin
                        rsp_d = 1'b1;
                        if (cur_op == OP_LOAD) rdata_d = hit_word;
                        if (cur_op == OP_STORE) begin
                           word_we    = 1'b1;
                           tag_we     = 1'b1;
                           tag_wvalid = 1'b1;
                           tag_wdirty = 1'b1;
                        end
                     end else begin
                        state_d = (lk_valid && lk_dirty) ? ST_WB : ST_RD;
                     end
                  end
                  OP_INVAL: begin
                     rsp_d = 1'b1;
                     if (hit) tag_we = 1'b1;
                  end
                  OP_REFRESH: begin
                     if (hit) state_d = ST_RD;
                     else     rsp_d   = 1'b1;
                  end
                  default: rsp_d = 1'b1;
               endcase
            end
         end
         ST_WB: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = {lk_tag, cur_idx};
            if (mem_req_ready) state_d = ST_RD;
         end
         ST_RD: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (mem_rsp_valid) begin
               line_we    = 1'b1;
               tag_we     = 1'b1;
               tag_wvalid = 1'b1;
               tag_wdirty = (cur_op == OP_STORE);
               rsp_d      = 1'b1;
               if (cur_op == OP_LOAD) rdata_d = fill_word;
               state_d    = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rsp_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         rsp_q   <= rsp_d;
         rdata_q <= rdata_d;
         if (accept) begin
            op_q    <= core_req_op;
            addr_q  <= core_req_addr;
            wdata_q <= core_req_wdata;
         end
      end
   end
endmodule

// File: rtl/swmc_cache.sv
module swmc_cache
   import swmc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int WORDS     = 4,
   parameter int NUM_LINES = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            core_req_valid,
   output logic                            core_req_ready,
   input  logic [2:0]                      core_req_op,
   input  logic [ADDR_W-1:0]               core_req_addr,
   input  logic [DATA_W-1:0]               core_req_wdata,
   output logic                            core_rsp_valid,
   output logic [DATA_W-1:0]               core_rsp_rdata,
   output logic                            mem_req_valid,
   input  logic                            mem_req_ready,
   output logic                            mem_req_write,
   output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_addr,
   output logic [WORDS*DATA_W-1:0]         mem_req_wdata,
   input  logic                            mem_rsp_valid,
   input  logic [WORDS*DATA_W-1:0]         mem_rsp_rdata
);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int LA_W   = ADDR_W - OFF_W;
   localparam int TAG_W  = LA_W - IDX_W;
   localparam int LINE_W = WORDS * DATA_W;

   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too narrow for offset and index");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic              lk_valid, lk_dirty;
   logic [TAG_W-1:0]  lk_tag;
   logic [LINE_W-1:0] line_rdata;
   logic              tag_we, tag_wvalid, tag_wdirty;
   logic [TAG_W-1:0]  tag_wtag;
   logic              line_we;
   logic [LINE_W-1:0] line_wdata;
   logic              word_we;
   logic [OFF_W-1:0]  word_off;
   logic [DATA_W-1:0] word_wdata;

   swmc_tag_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (lk_idx),
      .wr_en    (tag_we),
      .wr_valid (tag_wvalid),
      .wr_dirty (tag_wdirty),
      .wr_tag   (tag_wtag),
      .rd_valid (lk_valid),
      .rd_dirty (lk_dirty),
      .rd_tag   (lk_tag)
   );

   swmc_data_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .WORDS(WORDS),
                     .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
      .clk        (clk),
      .idx        (lk_idx),
      .line_we    (line_we),
      .line_wdata (line_wdata),
      .word_we    (word_we),
      .word_off   (word_off),
      .word_wdata (word_wdata),
      .line_rdata (line_rdata)
   );

   swmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .core_req_valid (core_req_valid),
      .core_req_ready (core_req_ready),
      .core_req_op    (core_req_op),
      .core_req_addr  (core_req_addr),
      .core_req_wdata (core_req_wdata),
      .core_rsp_valid (core_rsp_valid),
      .core_rsp_rdata (core_rsp_rdata),
      .lk_idx         (lk_idx),
      .lk_valid       (lk_valid),
      .lk_dirty       (lk_dirty),
      .lk_tag         (lk_tag),
      .line_rdata     (line_rdata),
      .tag_we         (tag_we),
      .tag_wvalid     (tag_wvalid),
      .tag_wdirty     (tag_wdirty),
      .tag_wtag       (tag_wtag),
      .line_we        (line_we),
      .line_wdata     (line_wdata),
      .word_we        (word_we),
      .word_off       (word_off),
      .word_wdata     (word_wdata),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_write  (mem_req_write),
      .mem_req_addr   (mem_req_addr),
      .mem_req_wdata  (mem_req_wdata),
      .mem_rsp_valid  (mem_rsp_valid),
      .mem_rsp_rdata  (mem_rsp_rdata)
   );
endmodule

// File: rtl/swmc_cache_chk.sv
module swmc_cache_chk
   import swmc_pkg::*;
#(
   parameter int LA_W   = 14,
   parameter int LINE_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_req_valid,
   input logic              core_req_ready,
   input logic [2:0]        core_req_op,
   input logic              core_rsp_valid,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [LA_W-1:0]   mem_req_addr,
   input logic [LINE_W-1:0] mem_req_wdata
);
   logic accept;
   assign accept = core_req_valid && core_req_ready;

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R9: assert (core_req_ready && !core_rsp_valid && !mem_req_valid);
      end
   end

   assert_busy_blocks_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !core_req_ready);

   assert_wb_then_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready && mem_req_write) |=> (mem_req_valid && !mem_req_write));

   assert_inval_no_traffic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && core_req_op == OP_INVAL) |=> (core_rsp_valid && !mem_req_valid));

   assert_refresh_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && core_req_op == OP_REFRESH) |=> !(mem_req_valid && mem_req_write));

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
         && $stable(mem_req_addr) && $stable(mem_req_wdata)));

   assert_unknown_op_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && core_req_op > OP_REFRESH) |=> (core_rsp_valid && !mem_req_valid));

   assert_rsp_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      core_rsp_valid |-> core_req_ready);
endmodule

bind swmc_cache swmc_cache_chk #(
   .LA_W   (ADDR_W - $clog2(WORDS)),
   .LINE_W (WORDS * DATA_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .core_req_valid (core_req_valid),
   .core_req_ready (core_req_ready),
   .core_req_op    (core_req_op),
   .core_rsp_valid (core_rsp_valid),
   .mem_req_valid  (mem_req_valid),
   .mem_req_ready  (mem_req_ready),
   .mem_req_write  (mem_req_write),
   .mem_req_addr   (mem_req_addr),
   .mem_req_wdata  (mem_req_wdata)
);

// File: tb/tb_swmc_cache.sv
`timescale 1ns/1ps
module tb_swmc_cache;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int WORDS  = 4;
   localparam int LA_W   = ADDR_W - 2;
   localparam int LINE_W = WORDS * DATA_W;
   localparam int MEM_LINES = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b1;
   logic              core_req_valid = 1'b0;
   logic              core_req_ready;
   logic [2:0]        core_req_op = '0;
   logic [ADDR_W-1:0] core_req_addr = '0;
   logic [DATA_W-1:0] core_req_wdata = '0;
   logic              core_rsp_valid;
   logic [DATA_W-1:0] core_rsp_rdata;
   logic              mem_req_valid;
   logic              mem_req_ready;
   logic              mem_req_write;
   logic [LA_W-1:0]   mem_req_addr;
   logic [LINE_W-1:0] mem_req_wdata;
   logic              mem_rsp_valid = 1'b0;
   logic [LINE_W-1:0] mem_rsp_rdata = '0;
   logic              mem_stall = 1'b0;

   int checks = 0;
   int errors = 0;
   int n_rd = 0;
   int n_wr = 0;
   int cycles = 0;

   always #2 clk = ~clk;
   assign mem_req_ready = ~mem_stall;

   swmc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .NUM_LINES(8)) dut (
      .clk(clk), .rst_n(rst_n),
      .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
      .core_req_op(core_req_op), .core_req_addr(core_req_addr),
      .core_req_wdata(core_req_wdata), .core_rsp_valid(core_rsp_valid),
      .core_rsp_rdata(core_rsp_rdata), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
   );

   // backing store model: initial word = 0x5000_0000 | line<<8 | word
   logic [LINE_W-1:0] mem [MEM_LINES];
   int                rd_cnt = 0;
   logic [5:0]        rd_la = '0;

   function automatic logic [31:0] init_word(int la, int w);
      return 32'h5000_0000 | (la << 8) | w;
   endfunction

   initial begin
      for (int l = 0; l < MEM_LINES; l++)
         for (int w = 0; w < WORDS; w++)
            mem[l][w*DATA_W +: DATA_W] = init_word(l, w);
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      mem_rsp_valid <= 1'b0;
      if (rd_cnt != 0) begin
         rd_cnt <= rd_cnt - 1;
         if (rd_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem[rd_la];
         end
      end
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            mem[mem_req_addr[5:0]] <= mem_req_wdata;
            n_wr <= n_wr + 1;
         end else begin
            rd_la  <= mem_req_addr[5:0];
            rd_cnt <= 3;
            n_rd   <= n_rd + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input int req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic run_op(input logic [2:0] op, input logic [15:0] addr,
                         input logic [31:0] wd, input bit chk, input logic [31:0] expv,
                         input int erd, input int ewr, input int req);
      int rd0, wr0, lat;
      rd0 = n_rd;
      wr0 = n_wr;
      @(negedge clk);
      check(core_req_ready, req, "ready before request", 32'(core_req_ready), 32'd1);
      core_req_valid = 1'b1;
      core_req_op    = op;
      core_req_addr  = addr;
      core_req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      core_req_valid = 1'b0;
      lat = 1;
      while (!core_rsp_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(core_rsp_valid, req, "response arrived", 32'(core_rsp_valid), 32'd1);
      if (chk) check(core_rsp_rdata == expv, req, "load data", core_rsp_rdata, expv);
      check(n_rd - rd0 == erd, req, "line reads", 32'(n_rd - rd0), 32'(erd));
      check(n_wr - wr0 == ewr, req, "line writes", 32'(n_wr - wr0), 32'(ewr));
      if (erd == 0) check(lat == 1, req, "latency", 32'(lat), 32'd1);
      else          check(lat > 1, req, "miss latency", 32'(lat), 32'd2);
   endtask

   typedef struct packed {
      logic [2:0]  op;
      logic [15:0] addr;
      logic [31:0] wdata;
      logic        chk;
      logic [31:0] expv;
      logic [3:0]  nrd;
      logic [3:0]  nwr;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 16'h0005, 32'h0,         1'b1, 32'h5000_0101, 4'd1, 4'd0, 4'd2},  // R2 cold miss
      '{3'd0, 16'h0006, 32'h0,         1'b1, 32'h5000_0102, 4'd0, 4'd0, 4'd1},  // R1 hit
      '{3'd1, 16'h0007, 32'hAAAA_0001, 1'b0, 32'h0,         4'd0, 4'd0, 4'd3},  // R3 store hit
      '{3'd0, 16'h0007, 32'h0,         1'b1, 32'hAAAA_0001, 4'd0, 4'd0, 4'd3},  // R3
      '{3'd0, 16'h0025, 32'h0,         1'b1, 32'h5000_0901, 4'd1, 4'd1, 4'd4},  // R4 dirty victim
      '{3'd0, 16'h0007, 32'h0,         1'b1, 32'hAAAA_0001, 4'd1, 4'd0, 4'd4},  // R4 written back
      '{3'd2, 16'h0008, 32'h0,         1'b0, 32'h0,         4'd1, 4'd0, 4'd5},  // R5 prefetch miss
      '{3'd0, 16'h000B, 32'h0,         1'b1, 32'h5000_0203, 4'd0, 4'd0, 4'd5},  // R5 now hits
      '{3'd2, 16'h0009, 32'h0,         1'b0, 32'h0,         4'd0, 4'd0, 4'd5},  // R5 prefetch hit
      '{3'd1, 16'h000A, 32'hBBBB_0002, 1'b0, 32'h0,         4'd0, 4'd0, 4'd3},  // R3
      '{3'd3, 16'h0008, 32'h0,         1'b0, 32'h0,         4'd0, 4'd0, 4'd6},  // R6 drop dirty
      '{3'd0, 16'h000A, 32'h0,         1'b1, 32'h5000_0202, 4'd1, 4'd0, 4'd6},  // R6 refetch
      '{3'd3, 16'h0030, 32'h0,         1'b0, 32'h0,         4'd0, 4'd0, 4'd8},  // R8
      '{3'd4, 16'h0010, 32'h0,         1'b0, 32'h0,         4'd0, 4'd0, 4'd8},  // R8
      '{3'd1, 16'h0011, 32'hCCCC_0003, 1'b0, 32'h0,         4'd1, 4'd0, 4'd3},  // R3 store miss
      '{3'd0, 16'h0011, 32'h0,         1'b1, 32'hCCCC_0003, 4'd0, 4'd0, 4'd3},  // R3 merged
      '{3'd4, 16'h0012, 32'h0,         1'b0, 32'h0,         4'd1, 4'd0, 4'd7},  // R7 refresh dirty
      '{3'd0, 16'h0011, 32'h0,         1'b1, 32'h5000_0401, 4'd0, 4'd0, 4'd7},  // R7 local data gone
      '{3'd0, 16'h0031, 32'h0,         1'b1, 32'h5000_0C01, 4'd1, 4'd0, 4'd7},  // R7 no writeback
      '{3'd5, 16'h0031, 32'h0,         1'b0, 32'h0,         4'd0, 4'd0, 4'd11}, // R11
      '{3'd0, 16'h0031, 32'h0,         1'b1, 32'h5000_0C01, 4'd0, 4'd0, 4'd11}  // R11 untouched
   };

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      check(core_req_ready == 1'b1, 9, "reset ready", 32'(core_req_ready), 32'd1);
      check(core_rsp_valid == 1'b0, 9, "reset rsp", 32'(core_rsp_valid), 32'd0);
      check(mem_req_valid == 1'b0, 9, "reset mem req", 32'(mem_req_valid), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].chk, VECS[i].expv,
                int'(VECS[i].nrd), int'(VECS[i].nwr), int'(VECS[i].req));
      end

      // R10 / R2: stalled memory keeps request stable and core blocked
      @(negedge clk);
      mem_stall = 1'b1;
      core_req_valid = 1'b1;
      core_req_op    = 3'd0;
      core_req_addr  = 16'h0045;
      @(posedge clk);
      @(negedge clk);
      core_req_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check(mem_req_valid && !mem_req_write, 10, "held read", 32'(mem_req_valid), 32'd1);
         check(mem_req_addr == 14'd17, 10, "held addr", 32'(mem_req_addr), 32'd17);
         check(!core_req_ready, 2, "ready low while busy", 32'(core_req_ready), 32'd0);
         @(negedge clk);
      end
      mem_stall = 1'b0;
      begin
         int t;
         t = 0;
         while (!core_rsp_valid && t < 100) begin
            @(negedge clk);
            t++;
         end
      end
      check(core_rsp_rdata == 32'h5000_1101, 10, "stalled fill data", core_rsp_rdata, 32'h5000_1101);

      // R9: reset mid-run invalidates all lines
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run_op(3'd0, 16'h0045, 32'h0, 1'b1, 32'h5000_1101, 1, 0, 9);

      // R3 / R4: store miss over a dirty victim
      run_op(3'd1, 16'h0045, 32'hDDDD_0004, 1'b0, 32'h0, 0, 0, 3);
      run_op(3'd1, 16'h0064, 32'hEEEE_0005, 1'b0, 32'h0, 1, 1, 4);
      run_op(3'd0, 16'h0045, 32'h0, 1'b1, 32'hDDDD_0004, 1, 1, 4);
      run_op(3'd0, 16'h0064, 32'h0, 1'b1, 32'hEEEE_0005, 1, 0, 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule